// File: doc/BRIEF.md
# Streaming 2x2 Max Pooling Unit

This block reduces a raster-ordered stream of convolved samples to its stride-2 maximum-pooled version. It accepts at most one signed sample per clock from an N-by-N frame (N even), and it emits one sample for every non-overlapping 2x2 tile. The result is an (N/2)-by-(N/2) stream in raster order. One instance serves one channel. Several channels use several instances.

The storage is a single line memory of N/2 words. On even rows, each horizontal pair of samples is reduced to its larger value, and that value is written at the pair's slot. On odd rows, the incoming pair is reduced the same way. Its maximum is then compared with the word stored for that slot, and the larger of the two is registered as the output. Input gaps are tolerated. A start pulse realigns the block to the top-left corner of a new frame. Without a start pulse, frames follow one another, with the row counter wrapping after N rows.

Top module: `maxpool2x2_stream`

## Requirements
- R1: While reset is held and in the first cycle after it, `pool_valid` is 0 and `pool_data` is 0.
- R2: A result is produced only for an accepted sample at an odd row and an odd column, counting rows and columns from 0. A complete frame produces exactly (N/2)*(N/2) results.
- R3: Each result equals the maximum of the four samples of its tile: rows 2i and 2i+1, columns 2j and 2j+1.
- R4: All comparisons treat samples as two's-complement signed values, so a tile of negative samples yields its least negative sample.
- R5: `pool_valid` rises in the cycle right after the tile's last sample is accepted, and it lasts exactly one cycle.
- R6: A cycle with `pix_valid` low advances no position counter and produces no result.
- R7: A `start` pulse returns the position to row 0, column 0, and the sample presented with it is discarded. The next frame is then pooled with no influence from the abandoned partial frame.
- R8: After the last sample of a frame, the next accepted sample is treated as row 0, column 0 of a new frame, with no start pulse needed.
- R9: `pool_data` keeps its value in every cycle where `pool_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Restart at top-left of a frame; sample in same cycle dropped |
| pix_valid | input | 1 | `pix_data` carries a sample this cycle |
| pix_data | input | DW | Signed input sample |
| pool_valid | output | 1 | One-cycle strobe marking a pooled result |
| pool_data | output | DW | Signed pooled result, held between strobes |

## Verification
Only one register stands between the last sample of a tile and the result. So the strobe for a tile is due one clock after the sample at an odd row and odd column is accepted, and at no other time. The bench drives every sample half a cycle before the capturing edge. It then inspects the outputs at the next falling edge, where the result for that sample must be present and no result may appear for any other sample. With back-to-back input, the first sample of a tile therefore sees its result N+2 clocks later. Idle cycles and start cycles are checked at that same falling edge: the strobe must be absent and the data unchanged.

// File: rtl/maxpool2x2_stream.sv
module maxpool2x2_stream #(
  parameter int DW = 18,
  parameter int N  = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 pix_valid,
  input  logic signed [DW-1:0] pix_data,
  output logic                 pool_valid,
  output logic signed [DW-1:0] pool_data
);

  localparam int HALF = N / 2;
  localparam int CW   = (N > 2) ? $clog2(N) : 1;
  localparam int AW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] col, row;
  logic signed [DW-1:0] left;
  logic signed [DW-1:0] line_mem [HALF];
  logic signed [DW-1:0] pair_max, stored, tile_max;
  logic [AW-1:0] slot;

  wire take     = pix_valid && !start;
  wire col_odd  = col[0];
  wire row_odd  = row[0];
  wire last_col = (col == CW'(N - 1));
  wire last_row = (row == CW'(N - 1));

  assign slot     = AW'(col >> 1);
  assign pair_max = (pix_data > left) ? pix_data : left;
  assign stored   = line_mem[slot];
  assign tile_max = (pair_max > stored) ? pair_max : stored;

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      col <= '0;
      row <= '0;
    end else if (pix_valid) begin
      if (last_col) begin
        col <= '0;
        row <= last_row ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) left <= '0;
    else if (take && !col_odd) left <= pix_data;
  end

  always_ff @(posedge clk) begin
    if (take && col_odd && !row_odd) line_mem[slot] <= pair_max;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pool_valid <= 1'b0;
      pool_data  <= '0;
    end else begin
      pool_valid <= take && col_odd && row_odd;
      if (take && col_odd && row_odd) pool_data <= tile_max;
    end
  end

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    pool_valid |=> !pool_valid);

  a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !pool_valid |-> $stable(pool_data));

  a_r2_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    pool_valid |-> $past(pix_valid && !start));

  a_r7_start_drops: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !pool_valid);

  a_r3_covers_last: assert property (@(posedge clk) disable iff (!rst_n)
    pool_valid |-> pool_data >= $past(pix_data));

endmodule

// File: tb/maxpool2x2_stream_test.sv
module maxpool2x2_stream_test;
  localparam int DW = 8;
  localparam int N  = 6;

  logic clk = 0, rst_n = 0, start = 0, pix_valid = 0;
  logic signed [DW-1:0] pix_data = '0;
  logic pool_valid;
  logic signed [DW-1:0] pool_data;

  int checks = 0, fails = 0, outs = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;
  int img [N][N];
  int last_out = 0;

  maxpool2x2_stream #(.DW(DW), .N(N)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid),
    .pix_data(pix_data), .pool_valid(pool_valid), .pool_data(pool_data));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return int'(signed'(8'(seed >> 16)));
  endfunction

  task automatic fill(input int kind);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        case (kind)
          0: img[r][c] = r * N + c - 10;
          1: img[r][c] = -1 - ((r * 7 + c * 13) % 120);
          default: img[r][c] = rnd();
        endcase
  endtask

  task automatic idle(input string req);
    pix_valid = 0; pix_data = DW'(rnd());
    @(negedge clk);
    chk(pool_valid == 0, req, int'(pool_valid), 0);
    chk(int'(pool_data) == last_out, "R9", int'(pool_data), last_out);
  endtask

  task automatic push(input int r, input int c, input string req);
    int e;
    pix_valid = 1; pix_data = DW'(img[r][c]);
    @(negedge clk);
    if (r % 2 == 1 && c % 2 == 1) begin
      e = img[r-1][c-1];
      if (img[r-1][c] > e) e = img[r-1][c];
      if (img[r][c-1] > e) e = img[r][c-1];
      if (img[r][c] > e) e = img[r][c];
      chk(pool_valid == 1, "R5", int'(pool_valid), 1);
      chk(int'(pool_data) == e, req, int'(pool_data), e);
      last_out = e;
      outs++;
    end else begin
      chk(pool_valid == 0, "R2", int'(pool_valid), 0);
      chk(int'(pool_data) == last_out, "R9", int'(pool_data), last_out);
    end
    pix_valid = 0;
  endtask

  task automatic frame(input int gaps, input string req);
    outs = 0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        if (gaps != 0 && ((r * N + c) % 3 == 1)) idle("R6");
        push(r, c, req);
      end
    chk(outs == (N/2)*(N/2), "R2", outs, (N/2)*(N/2));
  endtask

  initial begin
    @(negedge clk);
    chk(pool_valid == 0 && pool_data == 0, "R1", int'(pool_valid), 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pool_valid == 0 && pool_data == 0, "R1", int'(pool_data), 0);

    fill(0); frame(0, "R3");
    fill(1); frame(0, "R4");
    fill(2); frame(1, "R6");
    fill(2); frame(0, "R8");
    for (int k = 0; k < 4; k++) begin fill(2); frame(k % 2, "R3"); end

    fill(1);
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < N; c++) push(r, c, "R3");
    push(2, 0, "R3"); push(2, 1, "R3"); push(2, 2, "R3");
    start = 1; pix_valid = 1; pix_data = 8'sd127;
    @(negedge clk);
    chk(pool_valid == 0, "R7", int'(pool_valid), 0);
    start = 0; pix_valid = 0;
    fill(0);
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) img[r][c] = -img[r][c];
    frame(0, "R7");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule